// File: doc/BRIEF.md
# Cipher Phase Sequencer with Status and Error Flags

This block is the register-side control for a block-cipher peripheral. It moves through three phases in a fixed loop. In the load phase, software writes four 32-bit words through the data-in address. In the run phase, a fixed-latency stub datapath stands in for the cipher: it XORs the stored block with a 128-bit constant. In the unload phase, software reads four result words through the data-out address. Words move most significant first in both directions.

A status register reports four things: completion, a read-error flag, a write-error flag and a busy bit. A read of data-out before results exist returns zero and raises the read-error flag. A write to data-in during the run or unload phase is dropped and raises the write-error flag. Neither event disturbs the sequence. Sticky flags are cleared by write-one bits in the control register. A single interrupt line combines the completion source and the error source, each with its own enable.

Top module: `cipher_seq_status`

## Requirements
- R1: After reset, the control register, the status register, `bus_rdata` and `irq` are all zero.
- R2: Addresses are 0 control, 1 status, 2 data-in, 3 data-out. Status bit 0 is completion, bit 1 is read error, bit 2 is write error, bit 3 is busy, and bits 31:4 read as zero. A read's value appears on `bus_rdata` in the cycle after the request.
- R3: The fourth data-in write of a block starts the run phase. Busy reads as 1 for exactly LATENCY cycles. Then busy falls, the completion flag sets, and the unload phase begins.
- R4: Result word k equals input word k XOR bits [127-32k -: 32] of KEY. Word 0 is the first word written and the first word read.
- R5: The fourth data-out read returns the sequencer to the load phase, so blocks can follow back to back.
- R6: A data-out read in the load or run phase returns 0 and sets the read-error flag. The block in progress is unaffected.
- R7: A data-in write in the run or unload phase is discarded and sets the write-error flag. The block in progress is unaffected.
- R8: Completion stays set until a control write with bit 4 = 1. A control write with bit 5 = 1 clears both error flags at once. Control bits 3:0 are stored and read back.
- R9: When hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R10: `irq` = (completion AND control bit 1 AND NOT control bit 3) OR ((read error OR write error) AND control bit 2). Control bit 3 is the output-DMA mode.
- R11: A completion flag that is left set does not stop later blocks from loading, running or unloading.
- R12: Writing control bit 0 (enable) to 0 returns the sequencer to the load phase and discards partly loaded words. Status flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined completion/error interrupt |

## Verification
A table of four 128-bit blocks is pushed through the main path. It includes all-zero and all-one blocks, a block equal to the key, and a block whose four words differ. Together they show that each output word pairs with the right key slice, that the word order is not reversed, and that back-to-back blocks do not leak state into each other. Directed cases then cover the following:
- Status reads one cycle either side of the latency boundary, to pin the busy length.
- Accesses in the wrong phase, with the result data checked afterwards.
- A clear that lands on the same edge as completion.
- Each interrupt gating combination.
- An enable drop in the middle of a block.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_RUN    = 2'd1,
    PH_UNLOAD = 2'd2
  } phase_e;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIN  = 2'd2;
  localparam logic [ADDR_W-1:0] A_DOUT = 2'd3;

  // control register bit positions
  localparam int C_EN   = 0;
  localparam int C_DIE  = 1;
  localparam int C_EIE  = 2;
  localparam int C_ODMA = 3;
  localparam int C_DCLR = 4;
  localparam int C_ECLR = 5;
  localparam int CTRL_W = 4;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import cipher_seq_pkg::*;
#(
  parameter int WORDS   = 4,
  parameter int LATENCY = 10,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int LAT_W  = $clog2(LATENCY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             din_wr,
  input  logic             dout_rd,
  output phase_e           phase,
  output logic [IDX_W-1:0] word_idx,
  output logic             din_take,
  output logic             dout_give,
  output logic             done_pulse,
  output logic             busy,
  output logic             rd_err_set,
  output logic             wr_err_set
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATENCY - 1);

  logic [LAT_W-1:0] lat_cnt;

  assign busy       = (phase == PH_RUN);
  assign din_take   = din_wr && (phase == PH_LOAD) && enable;
  assign wr_err_set = din_wr && (phase != PH_LOAD);
  assign dout_give  = dout_rd && (phase == PH_UNLOAD);
  assign rd_err_set = dout_rd && (phase != PH_UNLOAD);
  assign done_pulse = enable && (phase == PH_RUN) && (lat_cnt == LAT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase    <= PH_LOAD;
      word_idx <= '0;
      lat_cnt  <= '0;
    end else begin
      case (phase)
        PH_LOAD: begin
          if (din_wr) begin
            if (word_idx == IDX_LAST) begin
              word_idx <= '0;
              lat_cnt  <= '0;
              phase    <= PH_RUN;
            end else begin
              word_idx <= word_idx + 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (lat_cnt == LAT_LAST) phase <= PH_UNLOAD;
          else lat_cnt <= lat_cnt + 1'b1;
        end
        PH_UNLOAD: begin
          if (dout_rd) begin
            if (word_idx == IDX_LAST) begin
              word_idx <= '0;
              phase    <= PH_LOAD;
            end else begin
              word_idx <= word_idx + 1'b1;
            end
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && enable) |-> (phase == PH_UNLOAD));

  // R5
  unload_wrap_chk: assert property (@(posedge clk) disable iff (rst || !enable)
    (dout_give && word_idx == IDX_LAST) |=> (phase == PH_LOAD));

endmodule

// File: rtl/stub_datapath.sv
module stub_datapath #(
  parameter int              WORDS  = 4,
  parameter int              DATA_W = 32,
  parameter logic [WORDS*DATA_W-1:0] KEY = '0,
  localparam int             IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              din_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  input  logic              capture,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] in_mem  [WORDS];
  logic [DATA_W-1:0] out_mem [WORDS];

  always_ff @(posedge clk) begin
    if (din_we) in_mem[idx] <= din;
  end

  // word 0 pairs with the most significant key slice
  always_ff @(posedge clk) begin
    if (capture) begin
      for (int k = 0; k < WORDS; k++) begin
        out_mem[k] <= in_mem[k] ^ KEY[(WORDS-1-k)*DATA_W +: DATA_W];
      end
    end
  end

  assign dout = out_mem[idx];

endmodule

// File: rtl/status_flags.sv
module status_flags (
  input  logic clk,
  input  logic rst,
  input  logic done_set,
  input  logic rerr_set,
  input  logic werr_set,
  input  logic done_clr,
  input  logic err_clr,
  input  logic done_ie,
  input  logic err_ie,
  input  logic out_dma,
  output logic done,
  output logic rerr,
  output logic werr,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      rerr <= 1'b0;
      werr <= 1'b0;
    end else begin
      done <= done_set | (done & ~done_clr);
      rerr <= rerr_set | (rerr & ~err_clr);
      werr <= werr_set | (werr & ~err_clr);
    end
  end

  assign irq = (done & done_ie & ~out_dma) | ((rerr | werr) & err_ie);

  // R9
  done_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    done_set |=> done);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !rerr_set && !werr_set) |=> (!rerr && !werr));

endmodule

// File: rtl/cipher_seq_status.sv
module cipher_seq_status
  import cipher_seq_pkg::*;
#(
  parameter int   WORDS   = 4,
  parameter int   DATA_W  = 32,
  parameter int   LATENCY = 10,
  parameter logic [WORDS*DATA_W-1:0] KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
  localparam int  IDX_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr, done_clr, err_clr;
  logic              din_wr, dout_rd;
  phase_e            phase;
  logic [IDX_W-1:0]  word_idx;
  logic              din_take, dout_give, done_pulse, busy;
  logic              rd_err_set, wr_err_set;
  logic              f_done, f_rerr, f_werr;
  logic [DATA_W-1:0] dp_dout;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:C_ECLR+1];

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign done_clr = ctrl_wr && bus_wdata[C_DCLR];
  assign err_clr  = ctrl_wr && bus_wdata[C_ECLR];
  assign din_wr   = bus_wr && (bus_addr == A_DIN);
  assign dout_rd  = bus_rd && (bus_addr == A_DOUT);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  seq_fsm #(.WORDS(WORDS), .LATENCY(LATENCY)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (ctrl_q[C_EN]),
    .din_wr     (din_wr),
    .dout_rd    (dout_rd),
    .phase      (phase),
    .word_idx   (word_idx),
    .din_take   (din_take),
    .dout_give  (dout_give),
    .done_pulse (done_pulse),
    .busy       (busy),
    .rd_err_set (rd_err_set),
    .wr_err_set (wr_err_set)
  );

  stub_datapath #(.WORDS(WORDS), .DATA_W(DATA_W), .KEY(KEY)) u_dp (
    .clk     (clk),
    .din_we  (din_take),
    .idx     (word_idx),
    .din     (bus_wdata),
    .capture (done_pulse),
    .dout    (dp_dout)
  );

  status_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .done_set (done_pulse),
    .rerr_set (rd_err_set),
    .werr_set (wr_err_set),
    .done_clr (done_clr),
    .err_clr  (err_clr),
    .done_ie  (ctrl_q[C_DIE]),
    .err_ie   (ctrl_q[C_EIE]),
    .out_dma  (ctrl_q[C_ODMA]),
    .done     (f_done),
    .rerr     (f_rerr),
    .werr     (f_werr),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= DATA_W'(ctrl_q);
        A_STAT:  bus_rdata <= DATA_W'({busy, f_werr, f_rerr, f_done});
        A_DOUT:  bus_rdata <= dout_give ? dp_dout : '0;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R6
  early_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_rd && phase != PH_UNLOAD) |=> (bus_rdata == '0));

  // R7
  late_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (din_wr && phase != PH_LOAD) |=> f_werr);

endmodule

// File: tb/tb_cipher_seq_status.sv
module tb_cipher_seq_status;

  localparam int LAT = 10;
  localparam logic [127:0] KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DIN = 2'd2, A_DOUT = 2'd3;

  localparam logic [127:0] VEC [4] = '{
    128'h00000000_00000000_00000000_00000000,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    128'h11111111_22222222_33333333_44444444
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  cipher_seq_status #(.LATENCY(LAT), .KEY(KEY)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] word_of(logic [127:0] b, int w);
    return b[127-32*w -: 32];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic load(logic [127:0] b);
    for (int w = 0; w < 4; w++) wr(A_DIN, word_of(b, w));
  endtask

  task automatic unload_check(string req, logic [127:0] b);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(A_DOUT, d);
      check(req, d, word_of(b ^ KEY, w));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_CTRL, d); check("R1 control", d, 32'h0);

    wr(A_CTRL, 32'h1);
    rd(A_CTRL, d); check("R8 control readback", d, 32'h1);

    // R4 R5 table of blocks, back to back
    for (int v = 0; v < 4; v++) begin
      load(VEC[v]);
      repeat (LAT + 1) @(negedge clk);
      unload_check("R4 R5 table", VEC[v]);
      wr(A_CTRL, 32'h11);
    end

    // R3 R2 busy length: read at edge E0+LAT then E0+LAT+1
    load(VEC[3]);
    repeat (LAT - 1) @(negedge clk);
    rd(A_STAT, d); check("R3 busy last cycle", d, 32'h8);
    rd(A_STAT, d); check("R3 R2 done after latency", d, 32'h1);
    unload_check("R3 result", VEC[3]);

    // R8 completion held until clear bit
    rd(A_STAT, d); check("R8 done held", d, 32'h1);
    wr(A_CTRL, 32'h11);
    rd(A_STAT, d); check("R8 done cleared", d, 32'h0);

    // R6 early read in load phase
    rd(A_DOUT, d); check("R6 load-phase read zero", d, 32'h0);
    rd(A_STAT, d); check("R6 read error flag", d, 32'h2);
    // R6 R7 wrong-phase accesses during run and unload
    load(VEC[2]);
    rd(A_DOUT, d); check("R6 run-phase read zero", d, 32'h0);
    wr(A_DIN, 32'hDEADBEEF);
    repeat (LAT) @(negedge clk);
    rd(A_STAT, d); check("R7 flags after run", d, 32'h7);
    wr(A_DIN, 32'hCAFEF00D);
    unload_check("R6 R7 result undisturbed", VEC[2]);

    // R10 interrupt gating
    check("R10 irq enables off", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h5);
    check("R10 irq error source", 32'(irq), 32'h1);
    wr(A_CTRL, 32'h25);
    rd(A_STAT, d); check("R8 error clear both", d, 32'h1);
    check("R10 irq after error clear", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h3);
    check("R10 irq done source", 32'(irq), 32'h1);
    wr(A_CTRL, 32'hB);
    check("R10 irq output dma gating", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h11);
    rd(A_STAT, d); check("R8 clear after irq", d, 32'h0);

    // R9 clear lands on completion edge
    load(VEC[3]);
    repeat (LAT - 1) @(negedge clk);
    wr(A_CTRL, 32'h11);
    rd(A_STAT, d); check("R9 set wins over clear", d, 32'h1);
    unload_check("R9 result", VEC[3]);

    // R11 done left set, output dma on
    wr(A_CTRL, 32'h9);
    load(VEC[1]);
    repeat (LAT + 1) @(negedge clk);
    unload_check("R11 next block with done set", VEC[1]);
    wr(A_CTRL, 32'h11);

    // R12 enable drop discards partial words, keeps flags
    rd(A_DOUT, d); check("R6 read zero before disable", d, 32'h0);
    wr(A_DIN, 32'hAAAAAAAA);
    wr(A_DIN, 32'hBBBBBBBB);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d); check("R12 flags kept", d, 32'h2);
    load(VEC[3]);
    repeat (LAT + 1) @(negedge clk);
    unload_check("R12 fresh block after re-enable", VEC[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule